// File: doc/BRIEF.md
# SPD Memory Sizing Engine

This block works out how much SDRAM sits in up to four module slots and what each module's ending address is, with no processor involved. On a start pulse it steps through the slots in ascending order. For each slot it asks an external serial-bus read engine for six bytes of the slot's presence-detect contents over a simple request/acknowledge port. It never multiplies. Instead it adds the base-2 logarithms of the geometry fields into a size exponent. It then turns that exponent into a power-of-two size in 8 MB units and adds it to a running end address.

Each slot owns two entries in an eight-entry row boundary table. The first entry receives the running end address after the slot's first side. The second receives it after the second side. The second side only has memory when the slot reports more than one physical bank. A slot whose read fails is treated as empty. A one-cycle done pulse marks the end of the scan, and a no-memory flag reports when no slot answered.

The FSM states are IDLE, READ, SIDE1, SIDE2 and DONE:

- IDLE moves to READ on start.
- READ stays put while fields remain to be read.
- READ moves to SIDE1 either after the last field or on a read error.
- SIDE1 always moves to SIDE2.
- SIDE2 moves to READ for the next slot, or to DONE after the last slot.
- DONE returns to IDLE.

Top module: `spd_size_engine`

## Requirements
- R1: Slots are scanned at device addresses DEV_BASE (0x50) upward in steps of 1. Within a slot the bytes are read in this order: 3, 4, 17, 6, 7, 5.
- R2: The size exponent is computed as -1 + (byte3 & 0xF) + (byte4 & 0xF) + log2(byte17) + log2({byte7, byte6}). Byte 7 forms the upper 8 bits of the 16-bit width and byte 6 the lower 8 bits.
- R3: log2 gives the index of the highest set bit, and -1 for a zero input.
- R4: When byte 5 is greater than 1, the second side equals the first side. Otherwise the second side adds nothing.
- R5: The exponent is converted to 8 MB units by subtracting 26. A negative unit count makes the side empty.
- R6: A side adds 2^units to the end address only when units < 8. Larger sides add nothing.
- R7: Table entry 2m holds the running end address after slot m's first side, and entry 2m+1 holds it after the second side. Values are 8 bits and wrap modulo 256. The table is exposed on bnd_flat, with entry i at bits [8i+7:8i].
- R8: A read answered with rd_err marks the slot absent and ends that slot's reads. Both of its entries then repeat the previous end address.
- R9: done is high for exactly one cycle after the last slot is written, and busy is low on the following cycle.
- R10: no_mem is high after a scan in which every slot was absent. It is cleared when the next scan starts.
- R11: rd_req, rd_dev and rd_idx stay unchanged until a cycle in which rd_ack is high.
- R12: After reset the table is all zero and busy, done and no_mem are low. While idle, the table does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a scan (sampled in IDLE) |
| rd_req | output | 1 | Byte read request to serial-bus engine |
| rd_dev | output | 7 | Device address of the request |
| rd_idx | output | 8 | Byte offset of the request |
| rd_ack | input | 1 | Read completed (one cycle) |
| rd_err | input | 1 | Read failed or not acknowledged, valid with rd_ack |
| rd_data | input | 8 | Read byte, valid with rd_ack |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| no_mem | output | 1 | No slot answered in the last scan |
| bnd_flat | output | 64 | Eight 8-bit row boundary entries |

## Verification
Some rules can be checked on every cycle, and the assertions cover those:

- The request hold rule.
- The device address range.
- The shape of the done pulse.
- The idle stability of the table and of no_mem.
- no_mem never being set while busy.

The arithmetic cannot be seen from single cycles. This covers the log sum, the 8 MB conversion, both limits of the unit window, the side duplication and the absent-slot repetition. Only the bench scenarios show these, by comparing the table with a behavioural model. The same applies to the exact read order, and to errors that arrive at the first, a middle or the last field.

// File: rtl/spd_size_pkg.sv
package spd_size_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_SIDE1,
        ST_SIDE2,
        ST_DONE
    } state_t;

    localparam int FIELD_CNT = 6;
    localparam logic [2:0] FLD_LAST = 3'(FIELD_CNT - 1);

    // byte offset fetched for each step of a slot's read sequence
    function automatic logic [7:0] field_offset(input logic [2:0] step);
        logic [7:0] off;
        case (step)
            3'd0:    off = 8'd3;
            3'd1:    off = 8'd4;
            3'd2:    off = 8'd17;
            3'd3:    off = 8'd6;
            3'd4:    off = 8'd7;
            default: off = 8'd5;
        endcase
        return off;
    endfunction

endpackage

// File: rtl/spd_log2.sv
module spd_log2 #(
    parameter int W  = 8,
    localparam int LW = $clog2(W) + 2
) (
    input  logic [W-1:0]         din,
    output logic signed [LW-1:0] lg
);
    always_comb begin
        lg = '1;  // -1 when no bit is set
        for (int i = 0; i < W; i++) begin
            if (din[i]) lg = LW'(i);
        end
    end
endmodule

// File: rtl/spd_side_calc.sv
module spd_side_calc #(
    parameter int EXP_W      = 8,
    parameter int BND_W      = 8,
    parameter int UNIT_SHIFT = 26,
    parameter int LIMIT_EXP  = 8,
    localparam int SH_W      = $clog2(BND_W)
) (
    input  logic signed [EXP_W-1:0] exp_bits,
    input  logic                    absent,
    input  logic                    two_side,
    output logic [BND_W-1:0]        add1,
    output logic [BND_W-1:0]        add2
);
    logic signed [EXP_W-1:0] units;
    logic                    in_win;
    logic [BND_W-1:0]        contrib;

    always_comb begin
        units   = exp_bits - EXP_W'(UNIT_SHIFT);
        in_win  = !units[EXP_W-1] && (units < $signed(EXP_W'(LIMIT_EXP)));
        contrib = in_win ? (BND_W'(1) << units[SH_W-1:0]) : '0;
        add1    = absent ? '0 : contrib;
        add2    = (absent || !two_side) ? '0 : contrib;
    end
endmodule

// File: rtl/spd_bnd_table.sv
module spd_bnd_table #(
    parameter int NREG  = 8,
    parameter int BND_W = 8,
    localparam int IW   = $clog2(NREG)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [IW-1:0]           widx,
    input  logic [BND_W-1:0]        wdata,
    output logic [NREG*BND_W-1:0]   flat
);
    for (genvar g = 0; g < NREG; g++) begin : g_ent
        logic [BND_W-1:0] ent;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         ent <= '0;
            else if (we && widx == IW'(g))      ent <= wdata;
        end
        assign flat[g*BND_W +: BND_W] = ent;
    end
endmodule

// File: rtl/spd_size_engine.sv
module spd_size_engine
    import spd_size_pkg::*;
#(
    parameter int         NUM_MOD    = 4,
    parameter logic [6:0] DEV_BASE   = 7'h50,
    parameter int         UNIT_SHIFT = 26,
    parameter int         LIMIT_EXP  = 8,
    parameter int         BND_W      = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    output logic                          rd_req,
    output logic [6:0]                    rd_dev,
    output logic [7:0]                    rd_idx,
    input  logic                          rd_ack,
    input  logic                          rd_err,
    input  logic [7:0]                    rd_data,
    output logic                          busy,
    output logic                          done,
    output logic                          no_mem,
    output logic [2*NUM_MOD*BND_W-1:0]    bnd_flat
);
    localparam int NREG  = 2 * NUM_MOD;
    localparam int IW    = $clog2(NREG);
    localparam int MW    = (NUM_MOD > 1) ? $clog2(NUM_MOD) : 1;
    localparam int EXP_W = 8;
    localparam int L8    = $clog2(8) + 2;
    localparam int L16   = $clog2(16) + 2;

    state_t state, nstate;

    logic [MW-1:0]           mod_q;
    logic [2:0]              fld_q;
    logic signed [EXP_W-1:0] acc_q;
    logic [7:0]              wlo_q;
    logic                    two_q, absent_q, any_q, nomem_q;
    logic [BND_W-1:0]        end_q;

    logic signed [L8-1:0]    lg8;
    logic signed [L16-1:0]   lg16;
    logic signed [EXP_W-1:0] lg8_x, lg16_x, nib_x;
    logic [BND_W-1:0]        add1, add2;
    logic                    tb_we;
    logic [IW-1:0]           tb_idx;
    logic [BND_W-1:0]        tb_wdata;
    logic                    last_mod;

    spd_log2 #(.W(8))  u_lg8  (.din(rd_data),          .lg(lg8));
    spd_log2 #(.W(16)) u_lg16 (.din({rd_data, wlo_q}), .lg(lg16));

    assign lg8_x    = {{(EXP_W-L8){lg8[L8-1]}}, lg8};
    assign lg16_x   = {{(EXP_W-L16){lg16[L16-1]}}, lg16};
    assign nib_x    = EXP_W'(rd_data[3:0]);
    assign last_mod = (mod_q == MW'(NUM_MOD - 1));

    spd_side_calc #(
        .EXP_W(EXP_W), .BND_W(BND_W),
        .UNIT_SHIFT(UNIT_SHIFT), .LIMIT_EXP(LIMIT_EXP)
    ) u_side (
        .exp_bits(acc_q), .absent(absent_q), .two_side(two_q),
        .add1(add1), .add2(add2)
    );

    spd_bnd_table #(.NREG(NREG), .BND_W(BND_W)) u_tab (
        .clk(clk), .rst_n(rst_n), .we(tb_we), .widx(tb_idx),
        .wdata(tb_wdata), .flat(bnd_flat)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // transitions
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:  if (start) nstate = ST_READ;
            ST_READ:  if (rd_ack && (rd_err || fld_q == FLD_LAST)) nstate = ST_SIDE1;
            ST_SIDE1: nstate = ST_SIDE2;
            ST_SIDE2: nstate = last_mod ? ST_DONE : ST_READ;
            ST_DONE:  nstate = ST_IDLE;
            default:  nstate = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rd_req   = 1'b0;
        busy     = 1'b1;
        done     = 1'b0;
        tb_we    = 1'b0;
        tb_idx   = '0;
        tb_wdata = end_q;
        unique case (state)
            ST_IDLE:  busy = 1'b0;
            ST_READ:  rd_req = 1'b1;
            ST_SIDE1: begin
                tb_we    = 1'b1;
                tb_idx   = IW'({mod_q, 1'b0});
                tb_wdata = end_q + add1;
            end
            ST_SIDE2: begin
                tb_we    = 1'b1;
                tb_idx   = IW'({mod_q, 1'b1});
                tb_wdata = end_q + add2;
            end
            ST_DONE:  done = 1'b1;
            default:  busy = 1'b0;
        endcase
    end

    assign rd_dev = DEV_BASE + 7'(mod_q);
    assign rd_idx = field_offset(fld_q);
    assign no_mem = nomem_q;

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mod_q <= '0;  fld_q <= '0;  acc_q <= '0;  wlo_q <= '0;
            two_q <= 1'b0; absent_q <= 1'b0; any_q <= 1'b0; nomem_q <= 1'b0;
            end_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    mod_q <= '0;  fld_q <= '0;  end_q <= '0;
                    two_q <= 1'b0; absent_q <= 1'b0; any_q <= 1'b0; nomem_q <= 1'b0;
                end
                ST_READ: if (rd_ack) begin
                    fld_q <= fld_q + 3'd1;
                    if (rd_err) absent_q <= 1'b1;
                    else begin
                        case (fld_q)
                            3'd0:    acc_q <= nib_x - EXP_W'(1);
                            3'd1:    acc_q <= acc_q + nib_x;
                            3'd2:    acc_q <= acc_q + lg8_x;
                            3'd3:    wlo_q <= rd_data;
                            3'd4:    acc_q <= acc_q + lg16_x;
                            default: begin
                                two_q <= (rd_data > 8'd1);
                                any_q <= 1'b1;
                            end
                        endcase
                    end
                end
                ST_SIDE1: end_q <= end_q + add1;
                ST_SIDE2: begin
                    end_q    <= end_q + add2;
                    mod_q    <= mod_q + MW'(1);
                    fld_q    <= '0;
                    two_q    <= 1'b0;
                    absent_q <= 1'b0;
                end
                ST_DONE: nomem_q <= !any_q;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/spd_size_chk.sv
module spd_size_chk #(
    parameter int         NUM_MOD  = 4,
    parameter logic [6:0] DEV_BASE = 7'h50,
    parameter int         FW       = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          rd_req,
    input logic [6:0]    rd_dev,
    input logic [7:0]    rd_idx,
    input logic          rd_ack,
    input logic          busy,
    input logic          done,
    input logic          no_mem,
    input logic [FW-1:0] bnd_flat
);
    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_ack |=> rd_req && $stable(rd_dev) && $stable(rd_idx));

    // R1
    dev_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_dev >= DEV_BASE) && (rd_dev < DEV_BASE + 7'(NUM_MOD)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    // R9
    req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> busy);

    // R12
    idle_tab_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> $stable(bnd_flat) && $stable(no_mem));

    // R10
    nomem_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        no_mem |-> !busy);
endmodule

bind spd_size_engine spd_size_chk #(
    .NUM_MOD(NUM_MOD), .DEV_BASE(DEV_BASE), .FW(2*NUM_MOD*BND_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req),
    .rd_dev(rd_dev), .rd_idx(rd_idx), .rd_ack(rd_ack), .busy(busy),
    .done(done), .no_mem(no_mem), .bnd_flat(bnd_flat)
);

// File: tb/tb_spd_size_engine.sv
`timescale 1ns/1ps
module tb_spd_size_engine;
    localparam int NM = 4;
    localparam int BW = 8;

    logic clk = 0;
    logic rst_n = 0;
    logic start = 0;
    logic rd_req, rd_ack, rd_err, busy, done, no_mem;
    logic [6:0] rd_dev;
    logic [7:0] rd_idx, rd_data;
    logic [2*NM*BW-1:0] bnd_flat;

    spd_size_engine dut (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req),
        .rd_dev(rd_dev), .rd_idx(rd_idx), .rd_ack(rd_ack), .rd_err(rd_err),
        .rd_data(rd_data), .busy(busy), .done(done), .no_mem(no_mem),
        .bnd_flat(bnd_flat)
    );

    always #5 clk = ~clk;

    int n_cmp = 0, n_bad = 0;
    int b3[NM], b4[NM], b17[NM], b6[NM], b7[NM], b5[NM], fail_at[NM];
    int rq[$];
    logic [2*NM*BW-1:0] exp_flat = '0;
    logic exp_nm = 0;
    bit cmp_on = 0;
    int done_cnt = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual %h expected %h", req, what, act, expv);
        end
    endtask

    function automatic int lg(input int v);
        int r = -1;
        for (int i = 0; i < 16; i++) if (v[i]) r = i;
        return r;
    endfunction

    function automatic int offs(input int f);
        case (f)
            0: return 3; 1: return 4; 2: return 17; 3: return 6; 4: return 7;
            default: return 5;
        endcase
    endfunction

    function automatic int lookup(input int m, input int idx);
        case (idx)
            3: return b3[m]; 4: return b4[m]; 17: return b17[m];
            6: return b6[m]; 7: return b7[m]; 5: return b5[m];
            default: return 0;
        endcase
    endfunction

    // behavioural reference: expected read list and table
    task automatic build_model();
        int e, u, c, endv;
        bit any;
        rq.delete();
        endv = 0; any = 0;
        for (int m = 0; m < NM; m++) begin
            for (int f = 0; f < 6; f++) begin
                rq.push_back(((m + 'h50) * 1024) + offs(f) * 2 + ((f == fail_at[m]) ? 1 : 0));
                if (f == fail_at[m]) break;
            end
            if (fail_at[m] < 6) begin
                exp_flat[(2*m)*BW +: BW]   = BW'(endv);
                exp_flat[(2*m+1)*BW +: BW] = BW'(endv);
            end else begin
                any = 1;
                e = -1 + (b3[m] & 15) + (b4[m] & 15) + lg(b17[m]) + lg(b7[m] * 256 + b6[m]);
                u = e - 26;
                c = (u >= 0 && u < 8) ? (1 << u) : 0;
                endv = (endv + c) % 256;
                exp_flat[(2*m)*BW +: BW] = BW'(endv);
                if (b5[m] > 1) endv = (endv + c) % 256;
                exp_flat[(2*m+1)*BW +: BW] = BW'(endv);
            end
        end
        exp_nm = !any;
    endtask

    task automatic set_mod(input int m, input int r, input int c, input int bk,
                           input int wl, input int wh, input int ph, input int fa);
        b3[m] = r; b4[m] = c; b17[m] = bk; b6[m] = wl; b7[m] = wh; b5[m] = ph;
        fail_at[m] = fa;
    endtask

    // serial-bus responder with per-read latency
    initial begin
        int wcnt = -1;
        int e;
        rd_ack = 0; rd_err = 0; rd_data = 0;
        forever begin
            @(negedge clk);
            if (rd_ack) begin
                rd_ack = 0; rd_err = 0; rd_data = 0; wcnt = -1;
            end else if (rd_req && rst_n) begin
                if (rq.size() == 0) begin
                    chk(0, "R1", "unexpected read", {rd_dev, rd_idx}, 0);
                end else begin
                    e = rq[0];
                    chk(int'(rd_dev) == e / 1024 && int'(rd_idx) == (e % 1024) / 2,
                        (wcnt < 0) ? "R1" : "R11", "read dev/idx",
                        {rd_dev, rd_idx}, 64'(e / 1024 * 256 + (e % 1024) / 2));
                    if (wcnt < 0) wcnt = (int'(rd_dev) + int'(rd_idx)) % 3;
                    if (wcnt == 0) begin
                        rd_ack  = 1;
                        rd_err  = e[0];
                        rd_data = 8'(lookup(e / 1024 - 'h50, (e % 1024) / 2));
                        void'(rq.pop_front());
                    end else wcnt--;
                end
            end
        end
    end

    // idle comparison on every cycle against the model
    initial forever begin
        @(negedge clk);
        if (cmp_on) begin
            chk(bnd_flat == exp_flat, "R7", "idle table", bnd_flat, exp_flat);
            chk(no_mem == exp_nm && !rd_req, "R10", "idle no_mem", no_mem, exp_nm);
        end
    end

    initial forever begin
        @(posedge clk); #1;
        if (done) done_cnt++;
    end

    task automatic run_scan(input string tag);
        int t = 0;
        int d0;
        build_model();
        cmp_on = 0;
        d0 = done_cnt;
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
        do begin @(negedge clk); t++; end while (!done && t < 5000);
        chk(t < 5000, "R9", {tag, " scan timeout"}, t, 0);
        @(negedge clk);
        chk(!busy && done_cnt == d0 + 1, "R9", {tag, " single done pulse"}, done_cnt - d0, 1);
        chk(rq.size() == 0, "R1", {tag, " reads left over"}, rq.size(), 0);
        chk(rq.size() == 0, "R8", {tag, " error stops slot reads"}, rq.size(), 0);
        for (int i = 0; i < 2 * NM; i++)
            chk(bnd_flat[i*BW +: BW] == exp_flat[i*BW +: BW], tag, $sformatf("entry %0d", i),
                bnd_flat[i*BW +: BW], exp_flat[i*BW +: BW]);
        chk(no_mem == exp_nm, "R10", {tag, " no_mem"}, no_mem, exp_nm);
        cmp_on = 1;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(bnd_flat == '0 && !busy && !done && !no_mem && !rd_req, "R12", "reset state",
            {bnd_flat[55:0], busy, done, no_mem, rd_req}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // S1: R2 sum, R3 zero bank byte, R4 both sides, R6 oversize slot
        set_mod(0, 12, 9, 4, 64, 0, 2, 6);
        set_mod(1, 13, 10, 4, 72, 0, 1, 6);
        set_mod(2, 13, 11, 0, 64, 0, 2, 6);
        set_mod(3, 15, 15, 8, 0, 1, 2, 6);
        run_scan("R2 R3 R4 R6 R7");

        // S2: R8 absent and mid-read error, R5 negative units, units 7
        set_mod(0, 12, 9, 4, 64, 0, 2, 0);
        set_mod(1, 1, 1, 1, 8, 0, 2, 6);
        set_mod(2, 13, 11, 4, 64, 0, 2, 2);
        set_mod(3, 13, 11, 4, 0, 1, 1, 6);
        run_scan("R5 R8 R7");

        // S3: R10 every slot absent
        for (int m = 0; m < NM; m++) set_mod(m, 12, 9, 4, 64, 0, 2, 0);
        run_scan("R10 R8");

        // S4: R6 units 8 dropped, R5 units 0, error on last field, R10 cleared
        set_mod(0, 13, 12, 4, 0, 1, 2, 6);
        set_mod(1, 12, 8, 4, 32, 0, 2, 6);
        set_mod(2, 13, 10, 4, 128, 0, 1, 6);
        set_mod(3, 13, 10, 4, 128, 0, 2, 5);
        run_scan("R5 R6 R8 R10");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL R9 watchdog expired actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule